// File: doc/BRIEF.md
# Touchscreen ADC SPI Responder

This block is the target side of a touchscreen converter that sits on an SPI link. Each completed byte transfer from the master arrives as a one-cycle strobe together with the received byte. One cycle later the block presents the byte it returns for that transfer. A received byte with its top bit set is a command. The command picks one of eight analog channels and starts a new conversion sequence. The two transfers that follow shift out the 12-bit result of that conversion, and every transfer after them returns zero.

The block does no real sampling. The touch X and touch Y channels return fixed parameter values. The other six channels take their values from a packed input port. The response for a transfer always depends on the state from before that transfer's byte is decoded, so a command byte only yields data on later transfers. The master's control-register writes carry a chip-select hold flag. A control write made while hold was not active drops the command state.

Channel numbers are 0 temperature 0, 1 touch Y, 2 battery voltage, 3 touch Z1, 4 touch Z2, 5 touch X, 6 microphone and 7 temperature 1.

Top module: `tsc_spi_responder`

## Requirements
- R1: After reset, `txValid` is 0, `txByte` is 0x00, no command is latched and the hold flag is clear.
- R2: `txValid` is 1 in the cycle after each `xferStb` and 0 in every other cycle. `txByte` changes only in the cycle after a transfer.
- R3: A received byte with bit 7 set is a command. Its bits 6:4 are latched as the channel and the result position restarts. The response to the command byte itself comes from the state before it.
- R4: The first transfer after a command captures the selected 12-bit channel value and returns its bits 11:5 in byte bits 6:0, with bit 7 zero.
- R5: The second transfer after a command returns bits 4:0 of the captured value in byte bits 7:3, with bits 2:0 zero. This holds even if the channel input has changed since the capture.
- R6: Every later transfer returns 0x00 until a new command byte is received.
- R7: While no command is latched, every transfer returns 0x00.
- R8: A control write (`ctrlWrite`) clears the command state if the hold flag it finds is 0. The write then loads the hold flag from `ctrlHold`. A control write that finds the hold flag at 1 leaves the command state untouched.
- R9: Channel 5 (touch X) returns the value 0x000 and channel 1 (touch Y) returns 0xFFF. These two channels have no slot in `extVals`. Channels 0, 2, 3, 4, 6 and 7 read 12-bit slots 0 to 5 of `extVals`, in that order; slot k is bits 12k+11:12k.
- R10: A command byte received part-way through a result sequence restarts the sequence on the new channel. Its own transfer still returns the byte due from the old sequence.
- R11: When a clearing control write and a command transfer happen in the same cycle, the clear wins and no command is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| xferStb | input | 1 | One-cycle pulse: a byte transfer has completed |
| rxByte | input | 8 | Byte received from the master in this transfer |
| ctrlWrite | input | 1 | One-cycle pulse: the master wrote its control register |
| ctrlHold | input | 1 | Chip-select hold flag carried by that control write |
| extVals | input | 72 | Six packed 12-bit channel values, slot order per R9 |
| txByte | output | 8 | Byte returned for the most recent transfer |
| txValid | output | 1 | High for one cycle after each transfer |

## Verification
The tests run a command on one channel, then keep transferring past the end of the result. This separates the high byte, the low byte and the zero tail, and distinguishes a 7/5 split from an even one. Changing the channel input between the two result bytes shows whether the value is captured or read live. Selecting X and Y while every external slot is set to all ones shows that those two channels ignore the port. Other tests send a command in place of the low byte, interleave control writes with hold set and cleared, and make a clearing write coincide with a command. Together these separate restart behaviour, hold tracking and clear priority.

// File: rtl/tsc_resp_pkg.sv
package tsc_resp_pkg;
  localparam int CH_SEL_W = 3;

  typedef enum logic [1:0] {
    PH_NONE = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2,
    PH_ZERO = 2'd3
  } phase_e;

  typedef struct packed {
    logic                xfer;
    logic                emitHigh;
    logic                emitLow;
    logic [CH_SEL_W-1:0] chan;
  } tscStrobes_t;
endpackage

// File: rtl/tsc_seq_ctrl.sv
module tsc_seq_ctrl
  import tsc_resp_pkg::*;
#(
  parameter int CMD_BIT = 7,
  parameter int CH_LSB  = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        xferStb,
  input  logic [7:0]  rxByte,
  input  logic        ctrlWrite,
  input  logic        ctrlHold,
  output tscStrobes_t stb
);
  phase_e              phase, phaseNext;
  logic [CH_SEL_W-1:0] chanQ, chanNext;
  logic                holdQ;
  logic                isCmd, clearReq;

  assign isCmd    = rxByte[CMD_BIT];
  assign clearReq = ctrlWrite && !holdQ;

  always_comb begin
    phaseNext = phase;
    chanNext  = chanQ;
    if (xferStb) begin
      if (isCmd) begin
        phaseNext = PH_HIGH;
        chanNext  = rxByte[CH_LSB +: CH_SEL_W];
      end else begin
        case (phase)
          PH_HIGH: phaseNext = PH_LOW;
          PH_LOW:  phaseNext = PH_ZERO;
          default: phaseNext = phase;
        endcase
      end
    end
    if (clearReq) phaseNext = PH_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_NONE;
      chanQ <= '0;
      holdQ <= 1'b0;
    end else begin
      phase <= phaseNext;
      chanQ <= chanNext;
      if (ctrlWrite) holdQ <= ctrlHold;
    end
  end

  always_comb begin
    stb.xfer     = xferStb;
    stb.emitHigh = xferStb && (phase == PH_HIGH);
    stb.emitLow  = xferStb && (phase == PH_LOW);
    stb.chan     = chanQ;
  end

  // R3
  cmd_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xferStb && rxByte[CMD_BIT] && !(ctrlWrite && !holdQ)) |=>
      (phase == PH_HIGH) && (chanQ == $past(rxByte[CH_LSB +: CH_SEL_W])));

  // R8
  unheld_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrite && !holdQ) |=> (phase == PH_NONE));

  // R8
  held_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrite && holdQ && !xferStb) |=> $stable(phase) && $stable(chanQ));

  // R6
  zero_tail_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_ZERO && !(xferStb && rxByte[CMD_BIT])) |=>
      (phase == PH_ZERO || phase == PH_NONE));

  // R7
  one_emit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.emitHigh, stb.emitLow}));
endmodule

// File: rtl/tsc_datapath.sv
module tsc_datapath
  import tsc_resp_pkg::*;
#(
  parameter int VAL_W   = 12,
  parameter int NUM_CH  = 8,
  parameter int HI_BITS = 7,
  parameter int X_CH    = 5,
  parameter int Y_CH    = 1,
  parameter int X_DEF   = 0,
  parameter int Y_DEF   = 4095,
  localparam int NUM_EXT = NUM_CH - 2,
  localparam int LO_BITS = VAL_W - HI_BITS,
  localparam int LO_PAD  = 8 - LO_BITS,
  localparam int HI_PAD  = 8 - HI_BITS
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  tscStrobes_t              stb,
  input  logic [NUM_EXT*VAL_W-1:0] extVals,
  output logic [7:0]               txByte,
  output logic                     txValid
);
  function automatic int extSlot(input int ch);
    int n = 0;
    for (int k = 0; k < ch; k++)
      if (k != X_CH && k != Y_CH) n++;
    return n;
  endfunction

  logic [VAL_W-1:0] chanArr [NUM_CH];
  logic [VAL_W-1:0] selVal, capReg;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    if (ch == X_CH) begin : g_x
      assign chanArr[ch] = VAL_W'(X_DEF);
    end else if (ch == Y_CH) begin : g_y
      assign chanArr[ch] = VAL_W'(Y_DEF);
    end else begin : g_ext
      assign chanArr[ch] = extVals[extSlot(ch)*VAL_W +: VAL_W];
    end
  end

  assign selVal = chanArr[stb.chan];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capReg  <= '0;
      txByte  <= '0;
      txValid <= 1'b0;
    end else begin
      txValid <= stb.xfer;
      if (stb.xfer) begin
        if (stb.emitHigh) begin
          capReg <= selVal;
          txByte <= {{HI_PAD{1'b0}}, selVal[VAL_W-1 -: HI_BITS]};
        end else if (stb.emitLow) begin
          txByte <= {capReg[LO_BITS-1:0], {LO_PAD{1'b0}}};
        end else begin
          txByte <= '0;
        end
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.xfer |=> txValid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.xfer |=> (!txValid && $stable(txByte)));

  // R4
  high_pad_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.emitHigh |=> (txByte[7 -: HI_PAD] == '0));

  // R5
  low_pad_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.emitLow |=> (txByte[LO_PAD-1:0] == '0));

  // R5
  cap_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.emitHigh |=> $stable(capReg));

  // R6
  plain_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.xfer && !stb.emitHigh && !stb.emitLow) |=> (txByte == 8'h00));
endmodule

// File: rtl/tsc_spi_responder.sv
module tsc_spi_responder
  import tsc_resp_pkg::*;
#(
  parameter int VAL_W   = 12,
  parameter int NUM_CH  = 8,
  parameter int HI_BITS = 7,
  parameter int X_CH    = 5,
  parameter int Y_CH    = 1,
  parameter int X_DEF   = 0,
  parameter int Y_DEF   = 4095,
  localparam int EXT_W  = (NUM_CH - 2) * VAL_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             xferStb,
  input  logic [7:0]       rxByte,
  input  logic             ctrlWrite,
  input  logic             ctrlHold,
  input  logic [EXT_W-1:0] extVals,
  output logic [7:0]       txByte,
  output logic             txValid
);
  tscStrobes_t stb;

  tsc_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .xferStb  (xferStb),
    .rxByte   (rxByte),
    .ctrlWrite(ctrlWrite),
    .ctrlHold (ctrlHold),
    .stb      (stb)
  );

  tsc_datapath #(
    .VAL_W  (VAL_W),
    .NUM_CH (NUM_CH),
    .HI_BITS(HI_BITS),
    .X_CH   (X_CH),
    .Y_CH   (Y_CH),
    .X_DEF  (X_DEF),
    .Y_DEF  (Y_DEF)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .extVals(extVals),
    .txByte (txByte),
    .txValid(txValid)
  );
endmodule

// File: tb/tb_tsc_spi_responder.sv
`timescale 1ns/1ps
module tb_tsc_spi_responder;
  localparam real CLK_PER = 8.0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        xferStb = 1'b0;
  logic [7:0]  rxByte = 8'h00;
  logic        ctrlWrite = 1'b0;
  logic        ctrlHold = 1'b0;
  logic [71:0] extVals = '0;
  logic [7:0]  txByte;
  logic        txValid;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  string curTag = "R1";

  always #(CLK_PER/2) clk = ~clk;

  tsc_spi_responder dut (
    .clk(clk), .rstN(rstN), .xferStb(xferStb), .rxByte(rxByte),
    .ctrlWrite(ctrlWrite), .ctrlHold(ctrlHold), .extVals(extVals),
    .txByte(txByte), .txValid(txValid)
  );

  function automatic int slotOf(input int ch);
    case (ch)
      0: return 0;
      2: return 1;
      3: return 2;
      4: return 3;
      6: return 4;
      default: return 5;
    endcase
  endfunction

  function automatic int chanValue(input int ch);
    if (ch == 5) return 0;
    if (ch == 1) return 'hFFF;
    return int'(extVals[slotOf(ch)*12 +: 12]);
  endfunction

  // behavioural reference: phase 0 none, 1 high due, 2 low due, 3 zero tail
  int mPhase = 0, mChan = 0, mCap = 0, mTx = 0;
  bit mHold = 0, mValid = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mChan = 0; mCap = 0; mTx = 0; mHold = 0; mValid = 0;
    end else begin
      mValid = xferStb;
      if (xferStb) begin
        if (mPhase == 1) begin
          mCap = chanValue(mChan);
          mTx  = mCap / 32;
        end else if (mPhase == 2) begin
          mTx = (mCap % 32) * 8;
        end else begin
          mTx = 0;
        end
        if (rxByte[7]) begin
          mPhase = 1;
          mChan  = (rxByte / 16) % 8;
        end else if (mPhase == 1) mPhase = 2;
        else if (mPhase == 2) mPhase = 3;
      end
      if (ctrlWrite) begin
        if (!mHold) mPhase = 0;
        mHold = ctrlHold;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (txValid !== mValid || txByte !== 8'(mTx)) begin
        errors++;
        $display("FAIL %s model compare: actual valid=%0b byte=%02h expected valid=%0b byte=%02h",
                 curTag, txValid, txByte, mValid, 8'(mTx));
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic doXfer(input logic [7:0] b, input int exp, input string tag);
    curTag = tag;
    @(negedge clk); xferStb = 1'b1; rxByte = b;
    @(negedge clk); xferStb = 1'b0; rxByte = 8'h00;
    #1;
    check(tag, int'(txByte), exp);
    check({tag, " valid"}, int'(txValid), 1);
  endtask

  task automatic ctrlWr(input logic h);
    @(negedge clk); ctrlWrite = 1'b1; ctrlHold = h;
    @(negedge clk); ctrlWrite = 1'b0; ctrlHold = 1'b0;
  endtask

  task automatic setCh(input int ch, input logic [11:0] v);
    extVals[slotOf(ch)*12 +: 12] = v;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset byte", int'(txByte), 0);
    check("R1 reset valid", int'(txValid), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R7: nothing latched yet
    doXfer(8'h00, 8'h00, "R7");
    doXfer(8'h35, 8'h00, "R7");

    // R3/R4/R5/R6 on channel 3
    setCh(3, 12'hABC);
    doXfer(8'hB0, 8'h00, "R3");
    doXfer(8'h00, 8'h55, "R4");
    setCh(3, 12'h000);
    doXfer(8'h00, 8'hE0, "R5");
    doXfer(8'h00, 8'h00, "R6");
    doXfer(8'h7F, 8'h00, "R6");

    // R2: idle cycle keeps the byte and drops valid
    curTag = "R2";
    @(negedge clk); #1;
    check("R2 idle valid", int'(txValid), 0);
    check("R2 idle byte", int'(txByte), 0);

    // R9: X and Y ignore the external port
    extVals = '1;
    doXfer(8'hD0, 8'h00, "R9");
    doXfer(8'h00, 8'h00, "R9 X high");
    doXfer(8'h00, 8'h00, "R9 X low");
    extVals = '0;
    doXfer(8'h90, 8'h00, "R9");
    doXfer(8'h00, 8'h7F, "R9 Y high");
    doXfer(8'h00, 8'hF8, "R9 Y low");

    // R10: new command in place of the low byte
    setCh(7, 12'h5A5);
    setCh(4, 12'h123);
    doXfer(8'hF0, 8'h00, "R10");
    doXfer(8'h00, 8'h2D, "R10 old high");
    doXfer(8'hC0, 8'h28, "R10 old low");
    doXfer(8'h00, 8'h09, "R10 new high");
    doXfer(8'h00, 8'h18, "R10 new low");

    // R8: hold tracking
    setCh(2, 12'h7FF);
    ctrlWr(1'b1);
    doXfer(8'hA0, 8'h00, "R8");
    ctrlWr(1'b1);
    doXfer(8'h00, 8'h3F, "R8 held keeps");
    ctrlWr(1'b0);
    doXfer(8'h00, 8'hF8, "R8 held keeps low");
    doXfer(8'hA0, 8'h00, "R8");
    ctrlWr(1'b0);
    doXfer(8'h00, 8'h00, "R8 unheld clears");
    doXfer(8'h00, 8'h00, "R8 unheld clears");

    // R11: clearing write at the same edge as a command
    curTag = "R11";
    @(negedge clk); xferStb = 1'b1; rxByte = 8'hA0; ctrlWrite = 1'b1; ctrlHold = 1'b0;
    @(negedge clk); xferStb = 1'b0; rxByte = 8'h00; ctrlWrite = 1'b0;
    #1;
    check("R11 same edge", int'(txByte), 0);
    doXfer(8'h00, 8'h00, "R11 no command");

    // R1: reset mid-sequence
    doXfer(8'hA0, 8'h00, "R1");
    @(negedge clk); rstN = 1'b0;
    #1;
    check("R1 async reset byte", int'(txByte), 0);
    @(negedge clk); rstN = 1'b1;
    doXfer(8'h00, 8'h00, "R1 command dropped");

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule